// File: doc/BRIEF.md
# UART Autobaud Rate Detector

This block times the start bit of the next character arriving on a UART receive line and turns that time into a divisor for the baud-rate generator. The divisor takes into account the oversampling factor that is currently configured. The calling logic raises the enable while the receiver is idle. The block then waits for a clean idle-to-start transition and counts the low period. It hands back the nearest divisor with a one-cycle write strobe. The measured character is still received and presented, so software can confirm that the expected character arrived.

The method works only when the first data bit of the measured character is 1. The start bit then ends on a rising edge. A timeout runs from the enable until the falling edge; if it expires, the block reports an error. Each enabled attempt ends in exactly one of two outcomes, ready or error. That outcome stays up until the calling logic drops the enable. The block ignores the enable while the port is in synchronous mode.

Top module: `uart_autobaud`

## Requirements
- R1: After reset, div_we_o, rx_ready_o and ab_err_o are low and div_o is 0.
- R2: The low time of the start bit is counted in clock cycles as N, after a two-flop synchronizer. The divisor is floor((N + floor(osr_i/2)) / osr_i) - 1. It appears on div_o together with a single-cycle div_we_o pulse.
- R3: The divisor rounds to nearest with halves going up. For example, N=24 with osr_i=16 gives 1, and N=23 gives 0.
- R4: A divisor above 16'hFFFF saturates to 16'hFFFF.
- R5: If the rounded quotient is 0, the block raises ab_err_o and does not pulse div_we_o.
- R6: The character is sampled LSB first over 8 data bits, each one measured period long, with one stop bit. rx_ready_o rises once both the character and the divisor are complete, and rx_data_o then holds the character.
- R7: If no falling edge arrives within timeout_i cycles (up to 4 cycles of pipeline slack) of the enable being accepted, ab_err_o rises and div_o is left untouched.
- R8: If the enable arrives while the line is low, the block waits for the line to go high before it arms the falling-edge detector. A partial low period is never measured.
- R9: While sync_mode_i is 1, the enable has no effect: no write, no ready and no error.
- R10: Ready and error are never both high. Each one holds while the enable stays high, and both clear one cycle after the enable drops.
- R11: div_o changes only with a div_we_o pulse and otherwise keeps its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| ab_en_i | input | 1 | Autobaud enable |
| sync_mode_i | input | 1 | Synchronous mode, disables autobaud |
| osr_i | input | OSR_W (5) | Oversampling factor, 1 or greater |
| timeout_i | input | TO_W (16) | Cycles allowed before the falling edge |
| div_o | output | DIV_W (16) | Computed baud divisor |
| div_we_o | output | 1 | Divisor write strobe |
| rx_data_o | output | DATA_W (8) | Measured character |
| rx_ready_o | output | 1 | Character and divisor ready |
| ab_err_o | output | 1 | Timeout or too-short start bit |

## Verification
Saturation is the hardest case to reach from the ports, because it needs a quotient beyond 16 bits. The stimulus sets an oversampling factor of 1 and holds the line low for 70000 cycles. It then checks the strobed divisor and drops the enable before the slow character could complete. The enable-while-low case also needs care: the line is held low before and after the enable rises. A wrong design would then measure 30 cycles instead of the full start bit.

// File: rtl/ab_pkg.sv
package ab_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_ARMED,
    ST_MEAS,
    ST_RECV,
    ST_DONE,
    ST_FAIL
  } ab_state_e;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ab_divider.sv
// Restoring divider, one quotient bit per cycle.
module ab_divider #(
  parameter int NUM_W = 21,
  parameter int DEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge;
  logic [DEN_W-1:0] rem_n;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, den_i};
  assign diff  = trial - {1'b0, den_i};
  assign rem_n = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= num_i;
      cnt_q  <= CW'(NUM_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= {quo_q[NUM_W-2:0], ge};
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/ab_bitrx.sv
// Samples data bits at mid-bit using the measured period; starts at the start-bit rising edge.
module ab_bitrx #(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int BW = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  tmr_q, per_q;
  logic [BW-1:0]     nbit_q;
  logic              busy_q, done_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      per_q  <= '0;
      nbit_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      per_q  <= period_i;
      tmr_q  <= period_i >> 1;
      nbit_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        tmr_q <= per_q - CNT_W'(1);
        if (nbit_q < BW'(DATA_W)) begin
          data_q <= {rx_i, data_q[DATA_W-1:1]};
          nbit_q <= nbit_q + BW'(1);
        end else begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        tmr_q <= tmr_q - CNT_W'(1);
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud
  import ab_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int OSR_W  = 5,
  parameter int TO_W   = 16,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              ab_en_i,
  input  logic              sync_mode_i,
  input  logic [OSR_W-1:0]  osr_i,
  input  logic [TO_W-1:0]   timeout_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              div_we_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic              ab_err_o
);
  localparam int NUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ab_state_e        state_q;
  logic             rx_s, rx_q, act;
  logic [CNT_W-1:0] cnt_q;
  logic [TO_W-1:0]  to_q;
  logic [DIV_W-1:0] div_q, div_next;
  logic             we_q, div_ok_q;
  logic             meas_end, div_done, rx_done;
  logic [NUM_W-1:0] num, quo, q_m1;

  ab_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_s;
  end

  assign act      = ab_en_i & ~sync_mode_i;
  assign meas_end = (state_q == ST_MEAS) && rx_s && act;
  assign num      = {1'b0, cnt_q} + NUM_W'(osr_i >> 1);

  ab_divider #(.NUM_W(NUM_W), .DEN_W(OSR_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(meas_end),
    .num_i  (num),
    .den_i  (osr_i),
    .done_o (div_done),
    .quo_o  (quo)
  );

  ab_bitrx #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_IDLE),
    .start_i (meas_end),
    .period_i(cnt_q),
    .rx_i    (rx_s),
    .done_o  (rx_done),
    .data_o  (rx_data_o)
  );

  assign q_m1 = quo - NUM_W'(1);

  generate
    if (NUM_W > DIV_W) begin : g_sat
      assign div_next = (|q_m1[NUM_W-1:DIV_W]) ? '1 : q_m1[DIV_W-1:0];
    end else begin : g_nosat
      assign div_next = DIV_W'(q_m1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      to_q     <= '0;
      div_q    <= '0;
      we_q     <= 1'b0;
      div_ok_q <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (!act) begin
        state_q  <= ST_IDLE;
        div_ok_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            to_q     <= '0;
            div_ok_q <= 1'b0;
            state_q  <= rx_s ? ST_ARMED : ST_WAIT_HI;
          end
          ST_WAIT_HI: begin
            if (to_q >= timeout_i) state_q <= ST_FAIL;
            else begin
              to_q <= to_q + TO_W'(1);
              if (rx_s) state_q <= ST_ARMED;
            end
          end
          ST_ARMED: begin
            if (rx_q && !rx_s) begin
              state_q <= ST_MEAS;
              cnt_q   <= CNT_W'(1);
            end else if (to_q >= timeout_i) begin
              state_q <= ST_FAIL;
            end else begin
              to_q <= to_q + TO_W'(1);
            end
          end
          ST_MEAS: begin
            if (rx_s)                  state_q <= ST_RECV;
            else if (cnt_q != CNT_MAX) cnt_q   <= cnt_q + CNT_W'(1);
          end
          ST_RECV: begin
            if (div_done) begin
              if (quo == '0) state_q <= ST_FAIL;
              else begin
                we_q     <= 1'b1;
                div_q    <= div_next;
                div_ok_q <= 1'b1;
              end
            end else if (rx_done && div_ok_q) begin
              state_q <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign div_o      = div_q;
  assign div_we_o   = we_q;
  assign rx_ready_o = (state_q == ST_DONE);
  assign ab_err_o   = (state_q == ST_FAIL);
endmodule

// File: rtl/ab_chk.sv
module ab_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ab_en_i,
  input logic             sync_mode_i,
  input logic [DIV_W-1:0] div_o,
  input logic             div_we_o,
  input logic             rx_ready_o,
  input logic             ab_err_o
);
  // R10
  no_dual_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && ab_err_o));

  // R9
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_en_i || sync_mode_i) |=> (!rx_ready_o && !ab_err_o && !div_we_o));

  // R2
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_o |=> !div_we_o);

  // R11
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_we_o |=> (div_we_o || $stable(div_o)));

  // R10
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ready_o && ab_en_i && !sync_mode_i) |=> rx_ready_o);

  // R10
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_err_o && ab_en_i && !sync_mode_i) |=> ab_err_o);

  // R5
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_err_o |-> !div_we_o);
endmodule

bind uart_autobaud ab_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ab_en_i    (ab_en_i),
  .sync_mode_i(sync_mode_i),
  .div_o      (div_o),
  .div_we_o   (div_we_o),
  .rx_ready_o (rx_ready_o),
  .ab_err_o   (ab_err_o)
);

// File: tb/tb_uart_autobaud.sv
module tb_uart_autobaud;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1, en = 1'b0, sync_m = 1'b0;
  logic [4:0]  osr = 5'd16;
  logic [15:0] tmo = 16'hFFFF;
  logic [15:0] div;
  logic        div_we, rdy, err;
  logic [7:0]  rdata;

  int n_chk = 0, n_fail = 0;

  typedef struct { bit err; logic [7:0] data; string req; } out_t;
  int   exp_div[$];
  out_t exp_out[$];

  always #5 clk = ~clk;

  uart_autobaud dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .ab_en_i(en), .sync_mode_i(sync_m),
    .osr_i(osr), .timeout_i(tmo), .div_o(div), .div_we_o(div_we),
    .rx_data_o(rdata), .rx_ready_o(rdy), .ab_err_o(err)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // monitor
  logic rdy_p = 1'b0, err_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (div_we) begin
        if (exp_div.size() == 0) chk(0, "R5", "unexpected div write", int'(div), -1);
        else begin
          int e;
          e = exp_div.pop_front();
          chk(int'(div) == e, "R2", "divisor", int'(div), e);
        end
      end
      if ((rdy && !rdy_p) || (err && !err_p)) begin
        if (exp_out.size() == 0) chk(0, "R10", "unexpected outcome", int'(err), -1);
        else begin
          out_t o;
          o = exp_out.pop_front();
          chk(err == o.err, o.req, "error flag", int'(err), int'(o.err));
          if (!o.err) chk(rdata == o.data, "R6", "rx data", int'(rdata), int'(o.data));
        end
      end
    end
    rdy_p <= rdy;
    err_p <= err;
  end

  task automatic send_frame(int bl, logic [7:0] d);
    rx = 1'b0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (bl) @(negedge clk);
    end
    rx = 1'b1;
    repeat (bl) @(negedge clk);
  endtask

  task automatic wait_outcome(int lim);
    for (int i = 0; i < lim; i++) begin
      if (rdy || err) break;
      @(negedge clk);
    end
  endtask

  task automatic drop_en();
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rdy && !err, "R10", "flags clear after enable drop", int'({rdy, err}), 0);
  endtask

  // driver: expectation from the requirement formula
  task automatic run_case(int o, int bl, logic [7:0] d, string req);
    int q;
    out_t e;
    q = (bl + o / 2) / o;
    e.data = d;
    e.req  = req;
    e.err  = (q == 0);
    if (q != 0) exp_div.push_back((q - 1 > 65535) ? 65535 : q - 1);
    exp_out.push_back(e);
    osr = 5'(o);
    en  = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(bl, d);
    wait_outcome(3000);
    chk(rdy || err, req, "outcome reached", int'({rdy, err}), 1);
    drop_en();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] d_keep;
    int t;
    out_t e;
    repeat (3) @(negedge clk);
    // R1
    chk(!div_we && !rdy && !err, "R1", "reset outputs", int'({div_we, rdy, err}), 0);
    chk(div == 16'd0, "R1", "reset divisor", int'(div), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_case(16, 160, 8'h55, "R2");
    run_case(8, 100, 8'hA3, "R2");
    run_case(4, 40, 8'hFF, "R6");
    run_case(16, 24, 8'h0F, "R3");
    run_case(16, 23, 8'h81, "R3");
    run_case(16, 7, 8'h01, "R5");

    // R7: timeout with idle line
    d_keep = div;
    tmo = 16'd50;
    e.err = 1'b1; e.data = 8'h00; e.req = "R7";
    exp_out.push_back(e);
    en = 1'b1;
    t = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      t++;
      if (err) break;
    end
    chk(t >= 50 && t <= 54, "R7", "timeout latency", t, 50);
    chk(div == d_keep, "R11", "divisor kept on timeout", int'(div), int'(d_keep));
    drop_en();
    tmo = 16'hFFFF;

    // R8: enable while line low
    rx = 1'b0;
    repeat (10) @(negedge clk);
    osr = 5'd16;
    e.err = 1'b0; e.data = 8'h3B; e.req = "R8";
    exp_out.push_back(e);
    exp_div.push_back(9);
    en = 1'b1;
    repeat (30) @(negedge clk);
    rx = 1'b1;
    repeat (20) @(negedge clk);
    send_frame(160, 8'h3B);
    wait_outcome(3000);
    chk(rdy, "R8", "ready after full start bit", int'(rdy), 1);
    chk(div == 16'd9, "R8", "divisor ignores partial low", int'(div), 9);
    drop_en();

    // R9: synchronous mode ignores enable
    d_keep = div;
    sync_m = 1'b1;
    en = 1'b1;
    repeat (4) @(negedge clk);
    send_frame(32, 8'h33);
    repeat (100) @(negedge clk);
    chk(!rdy && !err, "R9", "no outcome in sync mode", int'({rdy, err}), 0);
    chk(div == d_keep, "R9", "divisor unchanged in sync mode", int'(div), int'(d_keep));
    en = 1'b0;
    sync_m = 1'b0;
    repeat (4) @(negedge clk);

    // R4: saturation with osr 1 and a 70000-cycle start bit
    osr = 5'd1;
    exp_div.push_back(65535);
    en = 1'b1;
    repeat (4) @(negedge clk);
    rx = 1'b0;
    repeat (70000) @(negedge clk);
    rx = 1'b1;
    repeat (60) @(negedge clk);
    chk(div == 16'hFFFF, "R4", "saturated divisor", int'(div), 65535);
    chk(!rdy && !err, "R4", "no outcome before character ends", int'({rdy, err}), 0);
    drop_en();

    chk(exp_div.size() == 0, "R2", "pending divisor writes", exp_div.size(), 0);
    chk(exp_out.size() == 0, "R10", "pending outcomes", exp_out.size(), 0);
    finish_run();
  end
endmodule